// File: doc/BRIEF.md
# Interval Timer Channel

A single down-counting timer channel that produces a periodic tick, a terminal-count interrupt level or a one-shot strobe. Software drives it over a byte-wide register bus. One port select bit picks between a control port, which takes mode commands and count-freeze commands, and a data port, which loads the start count and returns the current or frozen count one byte at a time.

The counter advances only on clock cycles where the counter enable input is high. In this way, a slow timebase can be derived from the fast system clock. Once a mode has been chosen, a new start count is written as two data-port bytes, low byte first. Counting begins on the first enabled cycle after the second byte lands. A start count of zero stands for the full 65536-step range.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset the output is high, the count reads as 0, and data-port writes are ignored until a valid mode command has been written.
- R2: A control byte acts only when bits [7:6] are 00. If bits [5:4] are 00, it is a count-freeze command. If bits [5:4] are 11, it is a mode command, and it is accepted only when bit 0 is 0 and bits [3:1] are 000 (terminal count), 010 or 110 (rate), or 100 (strobe). For example, 0x30 is terminal count, 0x34 and 0x3C are rate, and 0x38 is strobe. Every other control byte leaves the output, the count and the read data unchanged.
- R3: A start count is taken from two data-port writes, low byte then high byte. It enters the counter on the first enabled cycle after the high byte. The count is unchanged before that cycle. A start count of 0 gives 65536 steps.
- R4: In rate mode with start count N ≥ 2, the output is high after the mode command. It is low for exactly one enabled cycle, the (N-1)th after the load, and high again on the Nth, when the counter reloads N. This repeats every N enabled cycles.
- R5: In terminal-count mode, the output goes low on the mode command and again whenever a new count is completed. It rises on the Nth enabled cycle after the load. It then stays high while the counter keeps decrementing and wraps.
- R6: In strobe mode, the output is high after the mode command. It goes low for exactly one enabled cycle, the Nth after the load, and does not pulse again. Writing both count bytes again, with no new control byte, re-arms a single pulse.
- R7: A freeze command copies the count. The next two data-port reads return the frozen low byte, then the frozen high byte. A further freeze command before both bytes have been read is ignored. Counting continues while the copy is held.
- R8: With no frozen copy held, data-port reads return the live count, alternating low byte then high byte.
- R9: A mode command stops the counter. The count holds its value through enabled cycles until a new start count is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Counter step enable, one step per high cycle |
| port_sel | input | 1 | 1 = control port, 0 = data port |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| rd_data | output | 8 | Read byte, valid while rd_en is high on the data port, else 0 |
| tmr_out | output | 1 | Timer output |

## Verification
The bench builds the block with its default 16-bit counter. This keeps the full zero-means-65536 run in reach, within about 65 thousand enabled cycles. The bench then sweeps small start counts exhaustively, tick by tick, in all three modes, predicting every output level and every count from the start value and the tick number. Byte-distinct counts such as 0x1234 make low/high ordering errors and freeze-timing errors visible. A batch of malformed control bytes is written in the middle of a rate period to confirm that the period is undisturbed.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_TERM   = 2'd0,
        MODE_RATE   = 2'd1,
        MODE_STROBE = 2'd2
    } itc_mode_e;

    typedef struct packed {
        logic      freeze;
        logic      set_mode;
        itc_mode_e mode;
    } itc_cmd_t;

    localparam logic [1:0] CHAN_OWN   = 2'b00;
    localparam logic [1:0] ACC_FREEZE = 2'b00;
    localparam logic [1:0] ACC_LOHI   = 2'b11;

    // Control byte layout: [7:6] channel, [5:4] access, [3:1] mode, [0] bcd.
    function automatic itc_cmd_t decode_ctrl(input logic [BYTE_W-1:0] b);
        itc_cmd_t c;
        c.freeze   = 1'b0;
        c.set_mode = 1'b0;
        c.mode     = MODE_TERM;
        if (b[7:6] == CHAN_OWN) begin
            if (b[5:4] == ACC_FREEZE) begin
                c.freeze = 1'b1;
            end else if (b[5:4] == ACC_LOHI && !b[0]) begin
                case (b[3:1])
                    3'b000: begin
                        c.set_mode = 1'b1;
                        c.mode     = MODE_TERM;
                    end
                    3'b010, 3'b110: begin
                        c.set_mode = 1'b1;
                        c.mode     = MODE_RATE;
                    end
                    3'b100: begin
                        c.set_mode = 1'b1;
                        c.mode     = MODE_STROBE;
                    end
                    default: c.set_mode = 1'b0;
                endcase
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/itc_load_seq.sv
module itc_load_seq #(
    parameter int COUNT_W = 16,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               data_wr,
    input  logic [BYTE_W-1:0]  wr_byte,
    output logic               load_req,
    output logic [COUNT_W-1:0] load_val
);
    localparam int NB = COUNT_W / BYTE_W;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic [PW-1:0] wptr_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wptr_q <= '0;
        end else if (data_wr) begin
            wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PW'(1);
        end
    end

    // Lower bytes are held; the top byte is taken straight from the bus.
    for (genvar g = 0; g < NB - 1; g++) begin : g_hold
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (data_wr && wptr_q == PW'(g)) begin
                byte_q <= wr_byte;
            end
        end
        assign load_val[g*BYTE_W +: BYTE_W] = byte_q;
    end

    assign load_val[(NB-1)*BYTE_W +: BYTE_W] = wr_byte;
    assign load_req = data_wr && (wptr_q == LAST);

endmodule

// File: rtl/itc_counter.sv
module itc_counter
    import itc_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               mode_wr,
    input  itc_mode_e          mode_new,
    input  logic               load_req,
    input  logic [COUNT_W-1:0] load_val,
    output logic [COUNT_W-1:0] count,
    output logic               tmr_out
);
    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] TWO = COUNT_W'(2);

    itc_mode_e          mode_q;
    logic [COUNT_W-1:0] cnt_q;
    logic [COUNT_W-1:0] reload_q;
    logic               cfg_q;
    logic               pend_q;
    logic               run_q;
    logic               fired_q;
    logic               out_q;
    logic               load_ok;

    assign load_ok = load_req && cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_TERM;
            cnt_q    <= '0;
            reload_q <= '0;
            cfg_q    <= 1'b0;
            pend_q   <= 1'b0;
            run_q    <= 1'b0;
            fired_q  <= 1'b0;
            out_q    <= 1'b1;
        end else if (mode_wr) begin
            mode_q  <= mode_new;
            cfg_q   <= 1'b1;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            fired_q <= 1'b0;
            out_q   <= (mode_new != MODE_TERM);
        end else if (load_ok) begin
            reload_q <= load_val;
            pend_q   <= 1'b1;
            if (mode_q == MODE_TERM) out_q <= 1'b0;
        end else if (tick) begin
            if (pend_q) begin
                cnt_q   <= reload_q;
                pend_q  <= 1'b0;
                run_q   <= 1'b1;
                fired_q <= 1'b0;
                if (mode_q == MODE_RATE)        out_q <= (reload_q != ONE);
                else if (mode_q == MODE_STROBE) out_q <= 1'b1;
            end else if (run_q) begin
                case (mode_q)
                    MODE_TERM: begin
                        cnt_q <= cnt_q - ONE;
                        if (cnt_q == ONE) out_q <= 1'b1;
                    end
                    MODE_RATE: begin
                        if (cnt_q == ONE) begin
                            cnt_q <= reload_q;
                            out_q <= (reload_q != ONE);
                        end else begin
                            cnt_q <= cnt_q - ONE;
                            out_q <= (cnt_q != TWO);
                        end
                    end
                    MODE_STROBE: begin
                        cnt_q <= cnt_q - ONE;
                        if (cnt_q == ONE && !fired_q) begin
                            out_q   <= 1'b0;
                            fired_q <= 1'b1;
                        end else begin
                            out_q <= 1'b1;
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    assign count   = cnt_q;
    assign tmr_out = out_q;

    AST_RATE_SINGLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RATE && run_q && !out_q && tick && !pend_q && !mode_wr
         && !load_req && reload_q != ONE) |=> out_q); // R4

    AST_TERM_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TERM && run_q && out_q && !mode_wr && !load_req) |=> out_q); // R5

    AST_STROBE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STROBE && fired_q && out_q && !pend_q && !mode_wr && !load_req)
        |=> out_q); // R6

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !(pend_q && tick)) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/itc_readback.sv
module itc_readback #(
    parameter int COUNT_W = 16,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               freeze_cmd,
    input  logic               data_rd,
    input  logic [COUNT_W-1:0] count,
    output logic [BYTE_W-1:0]  rd_byte
);
    localparam int NB = COUNT_W / BYTE_W;
    localparam int PW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [PW-1:0] LAST = PW'(NB - 1);

    logic               held_q;
    logic [COUNT_W-1:0] frozen_q;
    logic [PW-1:0]      rptr_q;
    logic [COUNT_W-1:0] src;
    logic [BYTE_W-1:0]  lanes [NB];

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            frozen_q <= '0;
            rptr_q   <= '0;
        end else if (freeze_cmd) begin
            if (!held_q) begin
                held_q   <= 1'b1;
                frozen_q <= count;
                rptr_q   <= '0;
            end
        end else if (data_rd) begin
            if (rptr_q == LAST) begin
                rptr_q <= '0;
                held_q <= 1'b0;
            end else begin
                rptr_q <= rptr_q + PW'(1);
            end
        end
    end

    assign src = held_q ? frozen_q : count;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[g] = src[g*BYTE_W +: BYTE_W];
    end

    assign rd_byte = lanes[rptr_q];

    AST_FREEZE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (held_q && !(data_rd && rptr_q == LAST)) |=> (held_q && $stable(frozen_q))); // R7

endmodule

// File: rtl/interval_timer_ch.sv
module interval_timer_ch
    import itc_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              port_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              tmr_out
);
    itc_cmd_t           cmd;
    logic               mode_wr;
    logic               freeze_cmd;
    logic               data_wr;
    logic               data_rd;
    logic               load_req;
    logic [COUNT_W-1:0] load_val;
    logic [COUNT_W-1:0] count;
    logic [BYTE_W-1:0]  rd_byte;

    assign cmd        = decode_ctrl(wr_data);
    assign mode_wr    = wr_en && port_sel && cmd.set_mode;
    assign freeze_cmd = wr_en && port_sel && cmd.freeze;
    assign data_wr    = wr_en && !port_sel;
    assign data_rd    = rd_en && !port_sel;

    itc_load_seq #(.COUNT_W(COUNT_W), .BYTE_W(BYTE_W)) u_load (
        .clk      (clk),
        .rst      (rst),
        .restart  (mode_wr),
        .data_wr  (data_wr),
        .wr_byte  (wr_data),
        .load_req (load_req),
        .load_val (load_val)
    );

    itc_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (cnt_en),
        .mode_wr  (mode_wr),
        .mode_new (cmd.mode),
        .load_req (load_req),
        .load_val (load_val),
        .count    (count),
        .tmr_out  (tmr_out)
    );

    itc_readback #(.COUNT_W(COUNT_W), .BYTE_W(BYTE_W)) u_rb (
        .clk        (clk),
        .rst        (rst),
        .freeze_cmd (freeze_cmd),
        .data_rd    (data_rd),
        .count      (count),
        .rd_byte    (rd_byte)
    );

    assign rd_data = data_rd ? rd_byte : '0;

    AST_OUT_HIGH_AT_RESET: assert property (@(posedge clk) rst |=> tmr_out); // R1

endmodule

// File: tb/interval_timer_ch_bench.sv
module interval_timer_ch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tmr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_timer_ch u_interval_timer_ch (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .port_sel (port_sel),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .tmr_out  (tmr_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] b);
        @(negedge clk);
        port_sel = 1'b1; wr_data = b; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk);
        port_sel = 1'b0; wr_data = v[7:0]; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        wr_data = v[15:8]; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        port_sel = 1'b0; rd_en = 1'b1;
        #1 b = rd_data;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(posedge clk); #1 cnt_en = 1'b0;
        end
    endtask

    task automatic read_frozen(output logic [15:0] v);
        logic [7:0] lo, hi;
        wr_ctrl(8'h00);
        rd_byte(lo);
        rd_byte(hi);
        v = {hi, lo};
    endtask

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        logic [15:0] prev;
        int term_n [6]   = '{2, 3, 5, 17, 256, 300};
        int rate_n [5]   = '{2, 3, 4, 7, 10};
        int strobe_n [4] = '{1, 2, 5, 9};
        logic [7:0] bad [8] = '{8'h74, 8'h14, 8'h24, 8'h35, 8'h3E, 8'h3A, 8'hC0, 8'hF4};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state and writes before any mode command
        check("R1 out after reset", tmr_out, 1);
        read_frozen(v);
        check("R1 count after reset", v, 0);
        wr_cnt(16'h0010);
        tick(3);
        check("R1 out with no mode", tmr_out, 1);
        read_frozen(v);
        check("R1 count with no mode", v, 0);

        // R5 / R3: terminal-count sweep
        prev = 16'h0000;
        foreach (term_n[i]) begin
            wr_ctrl(8'h30);
            check("R5 out low on mode", tmr_out, 0);
            wr_cnt(16'(term_n[i]));
            check("R5 out low on count", tmr_out, 0);
            read_frozen(v);
            check("R3 count held before tick", v, prev);
            tick(1);
            read_frozen(v);
            check("R3 count loaded", v, term_n[i]);
            tick(term_n[i] - 1);
            check("R5 out before terminal", tmr_out, 0);
            tick(1);
            check("R5 out at terminal", tmr_out, 1);
            tick(3);
            check("R5 out stays high", tmr_out, 1);
            read_frozen(v);
            check("R5 count wraps on", v, 16'hFFFD);
            prev = 16'hFFFD;
        end

        // R4 / R2: rate sweep, alternating both mode codes
        foreach (rate_n[i]) begin
            wr_ctrl((i % 2 == 0) ? 8'h34 : 8'h3C);
            check("R4 out high on mode", tmr_out, 1);
            wr_cnt(16'(rate_n[i]));
            tick(1);
            check("R4 out high at load", tmr_out, 1);
            for (int p = 0; p < 3; p++) begin
                for (int k = 1; k <= rate_n[i]; k++) begin
                    tick(1);
                    check("R4 rate pattern", tmr_out, (k == rate_n[i] - 1) ? 0 : 1);
                end
            end
        end

        // R2: malformed control bytes mid-period have no effect
        wr_ctrl(8'h34);
        wr_cnt(16'd5);
        tick(1);
        tick(2);
        foreach (bad[i]) wr_ctrl(bad[i]);
        check("R2 out after ignored bytes", tmr_out, 1);
        rd_byte(b);
        check("R2 live low after ignored bytes", b, 8'h03);
        rd_byte(b);
        check("R2 live high after ignored bytes", b, 8'h00);
        tick(1);
        check("R2 period undisturbed high", tmr_out, 1);
        tick(1);
        check("R2 period undisturbed low", tmr_out, 0);

        // R9: mode command stops counting
        wr_ctrl(8'h30);
        check("R9 out low on mode", tmr_out, 0);
        tick(10);
        read_frozen(v);
        check("R9 count held", v, 1);
        check("R9 out still low", tmr_out, 0);

        // R6: strobe sweep with rearm
        foreach (strobe_n[i]) begin
            wr_ctrl(8'h38);
            check("R6 out high on mode", tmr_out, 1);
            wr_cnt(16'(strobe_n[i]));
            tick(1);
            check("R6 out high at load", tmr_out, 1);
            for (int k = 1; k <= strobe_n[i] + 4; k++) begin
                tick(1);
                check("R6 strobe pattern", tmr_out, (k == strobe_n[i]) ? 0 : 1);
            end
            wr_cnt(16'(strobe_n[i]));
            tick(1);
            for (int k = 1; k <= strobe_n[i] + 2; k++) begin
                tick(1);
                check("R6 rearmed strobe", tmr_out, (k == strobe_n[i]) ? 0 : 1);
            end
        end

        // R7: frozen copy, repeated freeze ignored, counting continues
        wr_ctrl(8'h30);
        wr_cnt(16'h1234);
        tick(1);
        wr_ctrl(8'h00);
        tick(4);
        rd_byte(b);
        check("R7 frozen low", b, 8'h34);
        wr_ctrl(8'h00);
        tick(1);
        rd_byte(b);
        check("R7 frozen high", b, 8'h12);
        read_frozen(v);
        check("R7 counting continued", v, 16'h122F);

        // R8: live reads
        rd_byte(b);
        check("R8 live low", b, 8'h2F);
        rd_byte(b);
        check("R8 live high", b, 8'h12);
        tick(2);
        rd_byte(b);
        check("R8 live low after ticks", b, 8'h2D);
        rd_byte(b);
        check("R8 live high after ticks", b, 8'h12);

        // R3: zero start count means 65536 steps
        wr_ctrl(8'h30);
        wr_cnt(16'h0000);
        tick(1);
        read_frozen(v);
        check("R3 zero loaded", v, 0);
        tick(65535);
        check("R3 out before 65536", tmr_out, 0);
        read_frozen(v);
        check("R3 count one before end", v, 1);
        tick(1);
        check("R3 out at 65536", tmr_out, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1-all actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule